// File: doc/BRIEF.md
# Timer PWM mode generator

This block is a 16-bit timer core that produces a pulse-width-modulated waveform on a single output pin. Two 16-bit compare values shape the signal. The period compare ends each cycle and reloads the counter to FFFCh. The pulse compare moves the pin to its second level partway through the cycle. Two control inputs choose the level that each compare event applies. The counter advances once per prescaler tick, and a 2-bit select picks the tick rate.

Software loads the compare values one byte at a time through an 8-bit write port. A write to the high byte takes that compare out of service, and the later write to the low byte puts it back. The period event sets a sticky flag. The flag can raise an interrupt, gated by an enable and a global mask. When the modulation enable is low, the counter free-runs and wraps, the pin keeps its last level, and the compare matches set two separate compare flags instead.

The period of the cycle is (period value + 5) prescaler ticks. The five extra ticks are the four reload states FFFCh to FFFFh plus the zero state.

Top module: `pwm_timer`

## Requirements
- R1: After reset the count is 0000h, the internal level is 0, the pin is 0, all three flags and the interrupt are 0, and both compares are out of service with value 0000h.
- R2: Prescaler select code 00, 01 and 10 advance the counter once every 2, 4 and 8 clocks. Code 11 holds the count unchanged.
- R3: With modulation enabled, a tick on which the count equals an in-service period value loads FFFCh. One full cycle then lasts (period + 5) ticks.
- R4: With modulation enabled, a period match sets the level to lvl_on_period and a pulse match sets it to lvl_on_pulse. The level changes on the same clock edge as the count. When both values match at once, the period level wins.
- R5: pwm_out equals the internal level while out_en is 1 and is 0 while out_en is 0.
- R6: period_flag is set by a period match in modulation mode and stays set until a cycle with flag_clr high. If a set and a clear fall in the same cycle, the set wins.
- R7: With modulation disabled, count matches against the pulse and period values set pulse_oc_flag and period_oc_flag. With modulation enabled, these two flags are never set.
- R8: irq is 1 exactly when irq_en is 1, irq_mask is 0 and at least one of the three flags is set.
- R9: wr_addr 0 and 1 write the pulse compare high and low bytes, and wr_addr 2 and 3 write the period compare high and low bytes. A high-byte write takes that compare out of service. A low-byte write puts it back in service.
- R10: While pwm_en is 1, opm_en has no effect on any output.
- R11: With modulation disabled, the counter counts up by one per tick and wraps from FFFFh to 0000h. The level keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select: 0/1 pulse high/low, 2/3 period high/low |
| wr_data | input | 8 | Byte to write |
| presc_sel | input | 2 | Tick rate: 00 /2, 01 /4, 10 /8, 11 stopped |
| pwm_en | input | 1 | Modulation mode enable |
| opm_en | input | 1 | One-pulse request, overridden by pwm_en |
| out_en | input | 1 | Connects the level to the pin |
| lvl_on_period | input | 1 | Level applied on a period match |
| lvl_on_pulse | input | 1 | Level applied on a pulse match |
| irq_en | input | 1 | Interrupt enable |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks |
| flag_clr | input | 1 | Clears all flags for one cycle |
| pwm_out | output | 1 | Waveform pin |
| timer_count | output | 16 | Current count |
| period_flag | output | 1 | Sticky period event flag |
| pulse_oc_flag | output | 1 | Pulse compare flag, used outside modulation mode |
| period_oc_flag | output | 1 | Period compare flag, used outside modulation mode |
| irq | output | 1 | Interrupt request |

## Verification
A cycle-accurate model in the bench predicts every output on every clock. The waveform is then driven through several patterns:
- A low-then-high level pair separates which compare sets which level.
- Swapped levels at a slower tick rate confirm the rate selection.
- Equal pulse and period values expose the tie priority.

A half-written period value shows that a high-byte write removes the compare from service: the counter runs past the old period instead of reloading. Measured cycle lengths at three tick rates, one of them with opm_en also set, check the (period + 5) rule. A final switch out of modulation mode near FFFFh shows the wrap, the held level and the compare flags appearing only in that mode.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PWM      = 2'd1,
    MODE_ONE_SHOT = 2'd2
  } timer_mode_e;

  localparam int CMP_N      = 2;
  localparam int PULSE_IDX  = 0;
  localparam int PERIOD_IDX = 1;

  // Count of reload states that precede zero in each modulation cycle.
  localparam int RELOAD_GAP = 4;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRESC_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       tick
);

  logic [PRESC_W-1:0] phase;

  function automatic logic [PRESC_W-1:0] tap_mask(input logic [1:0] s);
    return PRESC_W'((1 << (s + 1)) - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  always_comb begin
    tick = (sel != 2'b11) && ((phase & tap_mask(sel)) == tap_mask(sel));
  end

  // R2: the fastest rate never ticks on two clocks in a row
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel == 2'b00) |=> !tick);

endmodule

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg #(
  parameter int                BYTE_W  = 8,
  parameter int                ADDR_W  = 2,
  parameter logic [ADDR_W-1:0] HI_ADDR = '0,
  parameter logic [ADDR_W-1:0] LO_ADDR = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BYTE_W-1:0]     wr_data,
  output logic [2*BYTE_W-1:0]   value,
  output logic                  armed
);

  localparam int VAL_W = 2 * BYTE_W;

  logic hi_wr, lo_wr;

  always_comb begin
    hi_wr = wr_en && (wr_addr == HI_ADDR);
    lo_wr = wr_en && (wr_addr == LO_ADDR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
      armed <= 1'b0;
    end else if (hi_wr) begin
      value[VAL_W-1:BYTE_W] <= wr_data;
      armed                 <= 1'b0;
    end else if (lo_wr) begin
      value[BYTE_W-1:0] <= wr_data;
      armed             <= 1'b1;
    end
  end

  // R9: a high-byte write removes the compare from service
  a_r9_hi_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr |=> !armed);
  // R9: a low-byte write puts it back and lands in the low byte
  a_r9_lo_arms: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wr |=> (armed && value[BYTE_W-1:0] == $past(wr_data)));

endmodule

// File: rtl/pwm_core.sv
module pwm_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  timer_mode_e       mode,
  input  logic [CNT_W-1:0]  pulse_val,
  input  logic              pulse_armed,
  input  logic [CNT_W-1:0]  period_val,
  input  logic              period_armed,
  input  logic              lvl_on_period,
  input  logic              lvl_on_pulse,
  input  logic              flag_clr,
  output logic [CNT_W-1:0]  count,
  output logic              level,
  output logic              period_flag,
  output logic              pulse_oc_flag,
  output logic              period_oc_flag
);

  localparam logic [CNT_W-1:0] RELOAD = {CNT_W{1'b1}} - CNT_W'(RELOAD_GAP - 1);

  logic pwm_on;
  logic eq_period, eq_pulse;
  logic period_hit, pulse_hit;
  logic oc_period_evt, oc_pulse_evt;

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur, input logic adv, input logic reload);
    if (!adv)   return cur;
    if (reload) return RELOAD;
    return cur + 1'b1;
  endfunction

  function automatic logic next_level(
    input logic cur, input logic per_hit, input logic pul_hit,
    input logic per_lvl, input logic pul_lvl);
    if (per_hit) return per_lvl;
    if (pul_hit) return pul_lvl;
    return cur;
  endfunction

  always_comb begin
    pwm_on        = (mode == MODE_PWM);
    eq_period     = period_armed && (count == period_val);
    eq_pulse      = pulse_armed && (count == pulse_val);
    period_hit    = tick && pwm_on && eq_period;
    pulse_hit     = tick && pwm_on && eq_pulse;
    oc_period_evt = tick && !pwm_on && eq_period;
    oc_pulse_evt  = tick && !pwm_on && eq_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count          <= '0;
      level          <= 1'b0;
      period_flag    <= 1'b0;
      pulse_oc_flag  <= 1'b0;
      period_oc_flag <= 1'b0;
    end else begin
      count          <= next_count(count, tick, period_hit);
      level          <= next_level(level, period_hit, pulse_hit, lvl_on_period, lvl_on_pulse);
      period_flag    <= (period_flag & ~flag_clr) | period_hit;
      pulse_oc_flag  <= (pulse_oc_flag & ~flag_clr) | oc_pulse_evt;
      period_oc_flag <= (period_oc_flag & ~flag_clr) | oc_period_evt;
    end
  end

  // R3: a period match reloads the counter to the top-minus-three state
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> (count == RELOAD));
  // R4: period match applies the period level
  a_r4_period_level: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> (level == $past(lvl_on_period)));
  // R4: a lone pulse match applies the pulse level
  a_r4_pulse_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_hit && !period_hit) |=> (level == $past(lvl_on_pulse)));
  // R6: the period event leaves the flag set
  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |=> period_flag);
  // R7: compare flags never rise out of a modulation cycle
  a_r7_no_pulse_oc_in_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_oc_flag) |-> !$past(pwm_on));
  a_r7_no_period_oc_in_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(period_oc_flag) |-> !$past(pwm_on));
  // R11: outside modulation mode the level holds
  a_r11_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> $stable(level));

endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic [1:0]             presc_sel,
  input  logic                   pwm_en,
  input  logic                   opm_en,
  input  logic                   out_en,
  input  logic                   lvl_on_period,
  input  logic                   lvl_on_pulse,
  input  logic                   irq_en,
  input  logic                   irq_mask,
  input  logic                   flag_clr,
  output logic                   pwm_out,
  output logic [2*BYTE_W-1:0]    timer_count,
  output logic                   period_flag,
  output logic                   pulse_oc_flag,
  output logic                   period_oc_flag,
  output logic                   irq
);

  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = $clog2(2 * CMP_N);

  timer_mode_e        mode;
  logic               tick;
  logic               level;
  logic [CNT_W-1:0]   cmp_val [CMP_N];
  logic [CMP_N-1:0]   cmp_armed;

  // Modulation takes precedence over a one-pulse request.
  always_comb begin
    if (pwm_en)      mode = MODE_PWM;
    else if (opm_en) mode = MODE_ONE_SHOT;
    else             mode = MODE_FREE;
  end

  pwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (presc_sel),
    .tick (tick)
  );

  for (genvar g = 0; g < CMP_N; g++) begin : g_cmp
    pwm_cmp_reg #(
      .BYTE_W (BYTE_W),
      .ADDR_W (ADDR_W),
      .HI_ADDR(ADDR_W'(2 * g)),
      .LO_ADDR(ADDR_W'(2 * g + 1))
    ) u_reg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .value  (cmp_val[g]),
      .armed  (cmp_armed[g])
    );
  end

  pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick          (tick),
    .mode          (mode),
    .pulse_val     (cmp_val[PULSE_IDX]),
    .pulse_armed   (cmp_armed[PULSE_IDX]),
    .period_val    (cmp_val[PERIOD_IDX]),
    .period_armed  (cmp_armed[PERIOD_IDX]),
    .lvl_on_period (lvl_on_period),
    .lvl_on_pulse  (lvl_on_pulse),
    .flag_clr      (flag_clr),
    .count         (timer_count),
    .level         (level),
    .period_flag   (period_flag),
    .pulse_oc_flag (pulse_oc_flag),
    .period_oc_flag(period_oc_flag)
  );

  always_comb begin
    pwm_out = out_en & level;
    irq     = irq_en & ~irq_mask & (period_flag | pulse_oc_flag | period_oc_flag);
  end

  // R2: the stop code freezes the count
  a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (presc_sel == 2'b11) |=> $stable(timer_count));
  // R8: no request leaves the block while masked or disabled
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && !irq_mask));

endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  presc_sel = '0;
  logic        pwm_en = 1'b0, opm_en = 1'b0, out_en = 1'b0;
  logic        lvl_on_period = 1'b0, lvl_on_pulse = 1'b0;
  logic        irq_en = 1'b0, irq_mask = 1'b0, flag_clr = 1'b0;
  logic        pwm_out, period_flag, pulse_oc_flag, period_oc_flag, irq;
  logic [15:0] timer_count;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pwm_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .presc_sel(presc_sel), .pwm_en(pwm_en), .opm_en(opm_en), .out_en(out_en),
    .lvl_on_period(lvl_on_period), .lvl_on_pulse(lvl_on_pulse), .irq_en(irq_en),
    .irq_mask(irq_mask), .flag_clr(flag_clr), .pwm_out(pwm_out),
    .timer_count(timer_count), .period_flag(period_flag),
    .pulse_oc_flag(pulse_oc_flag), .period_oc_flag(period_oc_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- scoreboard: model pushes, monitor pops ----------------
  typedef struct {
    logic [15:0] cnt;
    logic        lvl, pf, of1, of2;
  } snap_t;
  snap_t sb_q[$];

  logic [2:0]  m_phase;
  logic [15:0] m_cnt;
  logic [15:0] m_val [2];
  logic [1:0]  m_arm;
  logic        m_lvl, m_pf, m_of1, m_of2;

  always @(posedge clk) begin
    snap_t s;
    int    div;
    logic  tk, per_eq, pul_eq;
    if (!rst_n) begin
      m_phase = '0; m_cnt = '0; m_val[0] = '0; m_val[1] = '0; m_arm = '0;
      m_lvl = 0; m_pf = 0; m_of1 = 0; m_of2 = 0;
    end else begin
      div = 2 << presc_sel;
      tk = (presc_sel != 2'b11) && ((int'(m_phase) % div) == div - 1);
      m_phase = m_phase + 3'd1;
      per_eq = m_arm[1] && (m_cnt == m_val[1]);
      pul_eq = m_arm[0] && (m_cnt == m_val[0]);
      if (flag_clr) begin m_pf = 0; m_of1 = 0; m_of2 = 0; end
      if (tk) begin
        if (pwm_en) begin
          if (per_eq) begin
            m_cnt = 16'hFFFC; m_lvl = lvl_on_period; m_pf = 1;
          end else begin
            if (pul_eq) m_lvl = lvl_on_pulse;
            m_cnt = m_cnt + 16'd1;
          end
        end else begin
          if (pul_eq) m_of1 = 1;
          if (per_eq) m_of2 = 1;
          m_cnt = m_cnt + 16'd1;
        end
      end
      if (wr_en) begin
        if (wr_addr[0]) begin m_val[wr_addr[1]][7:0] = wr_data;  m_arm[wr_addr[1]] = 1; end
        else            begin m_val[wr_addr[1]][15:8] = wr_data; m_arm[wr_addr[1]] = 0; end
      end
    end
    s.cnt = m_cnt; s.lvl = m_lvl; s.pf = m_pf; s.of1 = m_of1; s.of2 = m_of2;
    sb_q.push_back(s);
  end

  always @(posedge clk) begin
    snap_t e;
    #2;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      chk("R3 count", timer_count, e.cnt);
      chk("R5 pin", pwm_out, out_en ? e.lvl : 1'b0);
      chk("R6 period_flag", period_flag, e.pf);
      chk("R7 oc flags", {pulse_oc_flag, period_oc_flag}, {e.of1, e.of2});
      chk("R8 irq", irq, irq_en && !irq_mask && (e.pf || e.of1 || e.of2));
    end
  end

  // ---------------- driver helpers ----------------
  task automatic sample();
    @(posedge clk); #3;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // waits until the count newly takes value v
  task automatic wait_entry(input logic [15:0] v, input int limit, input string req);
    logic [15:0] prev;
    sample();
    prev = timer_count;
    for (int i = 0; i < limit; i++) begin
      sample();
      if (timer_count == v && prev != v) return;
      prev = timer_count;
    end
    chk({req, " count never reached"}, timer_count, v);
  endtask

  task automatic measure(input int exp_clk, input string req);
    logic [15:0] prev;
    int n;
    wait_entry(16'hFFFC, 4 * exp_clk, req);
    prev = timer_count; n = 0;
    for (int i = 0; i < 4 * exp_clk; i++) begin
      sample(); n++;
      if (timer_count == 16'hFFFC && prev != 16'hFFFC) break;
      prev = timer_count;
    end
    chk({req, " cycle clocks"}, n, exp_clk);
  endtask

  task automatic run_all();
    logic [15:0] held;
    repeat (3) @(negedge clk);
    sample();
    chk("R1 reset count", timer_count, 16'h0000);
    chk("R1 reset pin/flags/irq", {pwm_out, period_flag, pulse_oc_flag, period_oc_flag, irq}, 5'b0);
    @(negedge clk); rst_n = 1;
    // pattern A: low then high, fastest rate
    @(negedge clk);
    presc_sel = 2'b00; pwm_en = 1; out_en = 1; irq_en = 1;
    lvl_on_period = 0; lvl_on_pulse = 1;
    wr(0, 8'h00); wr(1, 8'h08); wr(2, 8'h00); wr(3, 8'h14);
    measure((20 + 5) * 2, "R3 R2 div2");
    chk("R6 flag after period", period_flag, 1'b1);
    chk("R8 irq enabled", irq, 1'b1);
    @(negedge clk); irq_mask = 1;
    sample();
    chk("R8 irq masked", irq, 1'b0);
    @(negedge clk); presc_sel = 2'b11; flag_clr = 1;
    @(negedge clk); flag_clr = 0;
    sample();
    chk("R6 flag cleared", period_flag, 1'b0);
    held = timer_count;
    repeat (16) sample();
    chk("R2 stopped count", timer_count, held);
    // pattern B: swapped levels, divide by 4
    @(negedge clk); irq_mask = 0; presc_sel = 2'b01; lvl_on_period = 1; lvl_on_pulse = 0;
    wait_entry(16'h000C, 400, "R4");
    chk("R4 pulse level", pwm_out, 1'b0);
    wait_entry(16'hFFFE, 400, "R4");
    chk("R4 period level", pwm_out, 1'b1);
    measure((20 + 5) * 4, "R3 R2 div4");
    // pattern C: equal compares, period level must win
    @(negedge clk); lvl_on_period = 0; lvl_on_pulse = 1;
    wr(0, 8'h00); wr(1, 8'h14);
    wait_entry(16'hFFFD, 400, "R4");
    wait_entry(16'hFFFD, 400, "R4");
    chk("R4 tie period wins", pwm_out, 1'b0);
    // half-written period, pin disabled
    @(negedge clk); presc_sel = 2'b00; out_en = 0;
    sample();
    chk("R5 pin off", pwm_out, 1'b0);
    wr(2, 8'h00);
    wait_entry(16'h0030, 400, "R9 runs past disarmed period");
    chk("R9 no reload while disarmed", timer_count, 16'h0030);
    wr(3, 8'h40);
    wait_entry(16'hFFFC, 400, "R9 rearmed reload");
    chk("R9 rearmed reload", timer_count, 16'hFFFC);
    @(negedge clk); out_en = 1; opm_en = 1; presc_sel = 2'b10;
    measure((64 + 5) * 8, "R10 R2 div8 with opm");
    // free-run after leaving modulation mode
    wr(0, 8'h00); wr(1, 8'h02);
    wait_entry(16'hFFFC, 2000, "R11");
    wr(2, 8'h00); wr(3, 8'h03);
    @(negedge clk); presc_sel = 2'b00;
    wait_entry(16'h0002, 200, "R11");
    wait_entry(16'hFFFD, 200, "R11");
    chk("R7 no oc flags in pwm", {pulse_oc_flag, period_oc_flag}, 2'b00);
    @(negedge clk); pwm_en = 0;
    wait_entry(16'h0000, 40, "R11 wrap");
    chk("R11 wrap to zero", timer_count, 16'h0000);
    wait_entry(16'h0005, 40, "R11");
    chk("R7 oc flags outside pwm", {pulse_oc_flag, period_oc_flag}, 2'b11);
    chk("R11 level held", pwm_out, 1'b0);
    chk("R8 irq from oc flags", irq, 1'b1);
    repeat (4) sample();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule